// File: doc/BRIEF.md
# Camera Pixel Byte Formatter

This block turns a stream of processed pixel components into an 8-bit parallel data bus. It emits one byte on every clock while the line-active input is high. The source presents Y, U and V, or R, G and B, at its inputs. On each clock the formatter takes from those inputs the byte that belongs to the current slot of the selected output sequence. In YUV 4:2:2 mode, four slots carry two pixels. In packed RGB mode, two slots carry one 16-bit pixel word.

The output byte can pass through three optional steps. The U and V bytes can be replaced by two fixed values. The byte can then be limited to one of three code ranges. Finally the bus can be rearranged at bit level. All configuration inputs are static while a line is in progress. The data output and its line-active companion are registered, so both appear one clock after the inputs they are derived from.

Top module: `cam_byte_fmt`

## Requirements
- R1: While `line_act` is low, the next clock drives `pix_out` to 0x00 and `pix_act` low. A byte selected while `line_act` is high appears on `pix_out` one clock later, with `pix_act` high.
- R2: With `cfg_yuv_ylead` = 0 and `cfg_uv_swap` = 0, the YUV sequence is U, Y, V, Y and repeats every four bytes. The sequence returns to its first byte at every rising edge of `line_act`, even when the previous line stopped partway through the sequence.
- R3: With `cfg_yuv_ylead` = 1 and `cfg_uv_swap` = 0, the sequence is Y, U, Y, V.
- R4: `cfg_uv_swap` = 1 exchanges the U and V slots. The result is Y, V, Y, U when `cfg_yuv_ylead` = 1, and V, Y, U, Y when `cfg_yuv_ylead` = 0.
- R5: With `cfg_fix_uv` = 1, every U byte becomes `cfg_fix_u` and every V byte becomes `cfg_fix_v`. Y bytes still come from `in_y`.
- R6: With `cfg_rgb_en` = 1 and `cfg_rgb_mode` = 2'b01, each pixel becomes a 16-bit word {R[7:3], G[7:2], B[7:3]}. The high byte is sent first and the low byte second.
- R7: With `cfg_rgb_en` = 1 and `cfg_rgb_mode` = 2'b11, each pixel becomes a 16-bit word {1'b0, R[7:3], G[7:3], B[7:3]}, sent high byte first.
- R8: `cfg_rb_swap` = 1 exchanges the R and B fields in both packed RGB words.
- R9: If `cfg_rgb_en` = 0, or if `cfg_rgb_mode`[0] = 0, the block stays on the YUV path. In the first case `cfg_rgb_mode` has no effect.
- R10: `cfg_range` limits every byte before any bus rearrangement. Codes 2'b00 and 2'b01 clamp to 0x10..0xF0, code 2'b10 clamps to 0x01..0xFE, and code 2'b11 passes 0x00..0xFF unchanged.
- R11: `cfg_bit_rev` = 1 reverses the clamped byte, so bit i moves to bit 7-i.
- R12: `cfg_end_swap` = 1 exchanges bit 7 and bit 0 of the byte. This step comes after any bit reversal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| line_act | input | 1 | Line-active strobe; one output byte per clock while high |
| in_y | input | 8 | Luma component |
| in_u | input | 8 | U chroma component |
| in_v | input | 8 | V chroma component |
| in_r | input | 8 | Red component |
| in_g | input | 8 | Green component |
| in_b | input | 8 | Blue component |
| cfg_yuv_ylead | input | 1 | Start the YUV sequence with Y |
| cfg_uv_swap | input | 1 | Exchange the U and V slots |
| cfg_fix_uv | input | 1 | Use fixed chroma values |
| cfg_fix_u | input | 8 | Fixed U value |
| cfg_fix_v | input | 8 | Fixed V value |
| cfg_rgb_en | input | 1 | Enable RGB format |
| cfg_rgb_mode | input | 2 | RGB packing option |
| cfg_rb_swap | input | 1 | Exchange the R and B fields |
| cfg_range | input | 2 | Output code range select |
| cfg_bit_rev | input | 1 | Reverse the bit order of each byte |
| cfg_end_swap | input | 1 | Exchange bit 7 and bit 0 |
| pix_out | output | 8 | Registered output byte |
| pix_act | output | 1 | Registered line-active, aligned with `pix_out` |

## Verification
The bench first stops a line after three bytes and then starts a new one. A sequencer that did not restart at the line edge would begin the new line with a Y or V byte in place of U. Packed RGB uses different values in consecutive pixels, and the R/B exchange is also tested. These tests catch a wrong field boundary, a low-byte-first order, or a swap applied to G. The clamp is tested with the inputs 0x00 and 0xFF together with bit reversal. Reversing before clamping would produce 0x10 instead of 0x08. Combining bit reversal and the bit 7/bit 0 exchange shows that the two steps run in the required order.

// File: rtl/fmt_pkg.sv
package fmt_pkg;
  localparam int BYTE_W  = 8;
  localparam int PHASE_W = 2;
  localparam int R_BITS  = 5;
  localparam int G6_BITS = 6;

  typedef logic [BYTE_W-1:0]   byte_t;
  typedef logic [2*BYTE_W-1:0] word_t;
  typedef logic [PHASE_W-1:0]  phase_t;

  typedef enum logic [1:0] {
    RNG_STD_A = 2'b00,
    RNG_STD_B = 2'b01,
    RNG_EXT   = 2'b10,
    RNG_FULL  = 2'b11
  } range_e;

  localparam byte_t STD_LO = 8'h10;
  localparam byte_t STD_HI = 8'hF0;
  localparam byte_t EXT_LO = 8'h01;
  localparam byte_t EXT_HI = 8'hFE;
endpackage

// File: rtl/fmt_phase.sv
module fmt_phase
  import fmt_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  logic   line_act,
  output phase_t phase
);
  // Slot counter: held at zero outside a line so each line begins at slot 0.
  always_ff @(posedge clk) begin
    if (rst || !line_act) phase <= '0;
    else                  phase <= phase + 1'b1;
  end
endmodule

// File: rtl/fmt_select.sv
module fmt_select
  import fmt_pkg::*;
(
  input  phase_t     phase,
  input  byte_t      in_y,
  input  byte_t      in_u,
  input  byte_t      in_v,
  input  byte_t      in_r,
  input  byte_t      in_g,
  input  byte_t      in_b,
  input  logic       cfg_yuv_ylead,
  input  logic       cfg_uv_swap,
  input  logic       cfg_fix_uv,
  input  byte_t      cfg_fix_u,
  input  byte_t      cfg_fix_v,
  input  logic       cfg_rgb_en,
  input  logic [1:0] cfg_rgb_mode,
  input  logic       cfg_rb_swap,
  output byte_t      sel_byte
);
  logic               chroma_slot;
  logic               pick_v;
  byte_t              chroma;
  byte_t              yuv_byte;
  logic [R_BITS-1:0]  r5, b5, lead5, tail5;
  logic [G6_BITS-1:0] g6;
  word_t              word565, word555, rgb_word;
  logic               pack_en;

  always_comb begin
    // YUV 4:2:2 slot decode
    chroma_slot = cfg_yuv_ylead ? phase[0] : ~phase[0];
    pick_v      = phase[1] ^ cfg_uv_swap;
    if (cfg_fix_uv) chroma = pick_v ? cfg_fix_v : cfg_fix_u;
    else            chroma = pick_v ? in_v : in_u;
    yuv_byte = chroma_slot ? chroma : in_y;

    // RGB packing
    r5    = in_r[BYTE_W-1 -: R_BITS];
    b5    = in_b[BYTE_W-1 -: R_BITS];
    g6    = in_g[BYTE_W-1 -: G6_BITS];
    lead5 = cfg_rb_swap ? b5 : r5;
    tail5 = cfg_rb_swap ? r5 : b5;
    word565  = {lead5, g6, tail5};
    word555  = {1'b0, lead5, in_g[BYTE_W-1 -: R_BITS], tail5};
    rgb_word = cfg_rgb_mode[1] ? word555 : word565;
    pack_en  = cfg_rgb_en & cfg_rgb_mode[0];

    if (pack_en) sel_byte = phase[0] ? rgb_word[BYTE_W-1:0] : rgb_word[2*BYTE_W-1:BYTE_W];
    else         sel_byte = yuv_byte;
  end
endmodule

// File: rtl/fmt_range_bus.sv
module fmt_range_bus
  import fmt_pkg::*;
(
  input  byte_t      din,
  input  logic [1:0] cfg_range,
  input  logic       cfg_bit_rev,
  input  logic       cfg_end_swap,
  output byte_t      dout
);
  byte_t lo, hi, clamped, reversed, ordered;

  always_comb begin
    unique case (range_e'(cfg_range))
      RNG_EXT:  begin lo = EXT_LO; hi = EXT_HI; end
      RNG_FULL: begin lo = '0;     hi = '1;     end
      default:  begin lo = STD_LO; hi = STD_HI; end
    endcase
    if (din < lo)      clamped = lo;
    else if (din > hi) clamped = hi;
    else               clamped = din;
  end

  for (genvar i = 0; i < BYTE_W; i++) begin : g_rev
    assign reversed[i] = clamped[BYTE_W-1-i];
  end

  always_comb begin
    ordered = cfg_bit_rev ? reversed : clamped;
    dout    = ordered;
    if (cfg_end_swap) begin
      dout[BYTE_W-1] = ordered[0];
      dout[0]        = ordered[BYTE_W-1];
    end
  end
endmodule

// File: rtl/cam_byte_fmt.sv
module cam_byte_fmt
  import fmt_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       line_act,
  input  logic [7:0] in_y,
  input  logic [7:0] in_u,
  input  logic [7:0] in_v,
  input  logic [7:0] in_r,
  input  logic [7:0] in_g,
  input  logic [7:0] in_b,
  input  logic       cfg_yuv_ylead,
  input  logic       cfg_uv_swap,
  input  logic       cfg_fix_uv,
  input  logic [7:0] cfg_fix_u,
  input  logic [7:0] cfg_fix_v,
  input  logic       cfg_rgb_en,
  input  logic [1:0] cfg_rgb_mode,
  input  logic       cfg_rb_swap,
  input  logic [1:0] cfg_range,
  input  logic       cfg_bit_rev,
  input  logic       cfg_end_swap,
  output logic [7:0] pix_out,
  output logic       pix_act
);
  phase_t phase_q;
  byte_t  sel_byte;
  byte_t  bus_byte;

  fmt_phase u_phase (
    .clk      (clk),
    .rst      (rst),
    .line_act (line_act),
    .phase    (phase_q)
  );

  fmt_select u_select (
    .phase         (phase_q),
    .in_y          (in_y),
    .in_u          (in_u),
    .in_v          (in_v),
    .in_r          (in_r),
    .in_g          (in_g),
    .in_b          (in_b),
    .cfg_yuv_ylead (cfg_yuv_ylead),
    .cfg_uv_swap   (cfg_uv_swap),
    .cfg_fix_uv    (cfg_fix_uv),
    .cfg_fix_u     (cfg_fix_u),
    .cfg_fix_v     (cfg_fix_v),
    .cfg_rgb_en    (cfg_rgb_en),
    .cfg_rgb_mode  (cfg_rgb_mode),
    .cfg_rb_swap   (cfg_rb_swap),
    .sel_byte      (sel_byte)
  );

  fmt_range_bus u_range_bus (
    .din          (sel_byte),
    .cfg_range    (cfg_range),
    .cfg_bit_rev  (cfg_bit_rev),
    .cfg_end_swap (cfg_end_swap),
    .dout         (bus_byte)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      pix_out <= '0;
      pix_act <= 1'b0;
    end else begin
      pix_out <= line_act ? bus_byte : '0;
      pix_act <= line_act;
    end
  end
endmodule

// File: rtl/fmt_chk.sv
module fmt_chk (
  input logic       clk,
  input logic       rst,
  input logic       line_act,
  input logic       cfg_yuv_ylead,
  input logic       cfg_uv_swap,
  input logic       cfg_fix_uv,
  input logic [7:0] cfg_fix_u,
  input logic       cfg_rgb_en,
  input logic [1:0] cfg_rgb_mode,
  input logic [1:0] cfg_range,
  input logic       cfg_bit_rev,
  input logic       cfg_end_swap,
  input logic [1:0] phase,
  input logic [7:0] pix_out,
  input logic       pix_act
);
  logic plain_bus;
  logic yuv_path;
  assign plain_bus = !cfg_bit_rev && !cfg_end_swap;
  assign yuv_path  = !(cfg_rgb_en && cfg_rgb_mode[0]);

  assert_idle_zero_R1: assert property (@(posedge clk) disable iff (rst)
    !line_act |=> (pix_out == 8'h00 && !pix_act));

  assert_active_flag_R1: assert property (@(posedge clk) disable iff (rst)
    line_act |=> pix_act);

  assert_line_restart_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(line_act) |-> (phase == 2'd0));

  assert_fixed_u_R5: assert property (@(posedge clk) disable iff (rst)
    (line_act && cfg_fix_uv && yuv_path && !cfg_yuv_ylead && !cfg_uv_swap &&
     phase == 2'd0 && cfg_range == 2'b11 && plain_bus) |=> (pix_out == cfg_fix_u));

  assert_555_top_zero_R7: assert property (@(posedge clk) disable iff (rst)
    (line_act && cfg_rgb_en && cfg_rgb_mode == 2'b11 && !phase[0] &&
     cfg_range == 2'b11 && plain_bus) |=> !pix_out[7]);

  assert_std_range_R10: assert property (@(posedge clk) disable iff (rst)
    (line_act && !cfg_range[1] && plain_bus) |=> (pix_out >= 8'h10 && pix_out <= 8'hF0));

  assert_ext_range_R10: assert property (@(posedge clk) disable iff (rst)
    (line_act && cfg_range == 2'b10 && plain_bus) |=> (pix_out >= 8'h01 && pix_out <= 8'hFE));
endmodule

bind cam_byte_fmt fmt_chk u_fmt_chk (
  .clk           (clk),
  .rst           (rst),
  .line_act      (line_act),
  .cfg_yuv_ylead (cfg_yuv_ylead),
  .cfg_uv_swap   (cfg_uv_swap),
  .cfg_fix_uv    (cfg_fix_uv),
  .cfg_fix_u     (cfg_fix_u),
  .cfg_rgb_en    (cfg_rgb_en),
  .cfg_rgb_mode  (cfg_rgb_mode),
  .cfg_range     (cfg_range),
  .cfg_bit_rev   (cfg_bit_rev),
  .cfg_end_swap  (cfg_end_swap),
  .phase         (phase_q),
  .pix_out       (pix_out),
  .pix_act       (pix_act)
);

// File: tb/cam_byte_fmt_bench.sv
module cam_byte_fmt_bench;
  localparam int CLK_P = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       line_act = 1'b0;
  logic [7:0] in_y = '0, in_u = '0, in_v = '0, in_r = '0, in_g = '0, in_b = '0;
  logic       cfg_yuv_ylead = 1'b0, cfg_uv_swap = 1'b0, cfg_fix_uv = 1'b0;
  logic [7:0] cfg_fix_u = '0, cfg_fix_v = '0;
  logic       cfg_rgb_en = 1'b0;
  logic [1:0] cfg_rgb_mode = 2'b00;
  logic       cfg_rb_swap = 1'b0;
  logic [1:0] cfg_range = 2'b11;
  logic       cfg_bit_rev = 1'b0, cfg_end_swap = 1'b0;
  logic [7:0] pix_out;
  logic       pix_act;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  cam_byte_fmt u_cam_byte_fmt (
    .clk (clk), .rst (rst), .line_act (line_act),
    .in_y (in_y), .in_u (in_u), .in_v (in_v),
    .in_r (in_r), .in_g (in_g), .in_b (in_b),
    .cfg_yuv_ylead (cfg_yuv_ylead), .cfg_uv_swap (cfg_uv_swap),
    .cfg_fix_uv (cfg_fix_uv), .cfg_fix_u (cfg_fix_u), .cfg_fix_v (cfg_fix_v),
    .cfg_rgb_en (cfg_rgb_en), .cfg_rgb_mode (cfg_rgb_mode), .cfg_rb_swap (cfg_rb_swap),
    .cfg_range (cfg_range), .cfg_bit_rev (cfg_bit_rev), .cfg_end_swap (cfg_end_swap),
    .pix_out (pix_out), .pix_act (pix_act)
  );

  task automatic check(input logic [7:0] act, input logic [7:0] exp, input string req);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic defaults();
    @(negedge clk);
    line_act = 1'b0;
    cfg_yuv_ylead = 1'b0; cfg_uv_swap = 1'b0; cfg_fix_uv = 1'b0;
    cfg_rgb_en = 1'b0; cfg_rgb_mode = 2'b00; cfg_rb_swap = 1'b0;
    cfg_range = 2'b11; cfg_bit_rev = 1'b0; cfg_end_swap = 1'b0;
    in_y = 8'h40; in_u = 8'h21; in_v = 8'h93;
  endtask

  // Drive one active byte slot and check the byte one clock later.
  task automatic step(input logic [7:0] exp, input string req);
    @(negedge clk);
    line_act = 1'b1;
    @(posedge clk);
    #1;
    check(pix_out, exp, req);
    check({7'd0, pix_act}, 8'h01, "R1 pix_act");
  endtask

  task automatic end_line();
    @(negedge clk);
    line_act = 1'b0;
    @(posedge clk);
    #1;
    check(pix_out, 8'h00, "R1 idle data");
    check({7'd0, pix_act}, 8'h00, "R1 idle flag");
  endtask

  task automatic t_reset();
    check(pix_out, 8'h00, "R1 reset data");
    check({7'd0, pix_act}, 8'h00, "R1 reset flag");
  endtask

  task automatic t_uyvy_restart();
    defaults();
    step(8'h21, "R2 U"); step(8'h40, "R2 Y"); step(8'h93, "R2 V");
    step(8'h40, "R2 Y"); step(8'h21, "R2 wrap U");
    end_line();
    step(8'h21, "R2 U"); step(8'h40, "R2 Y"); step(8'h93, "R2 V");
    end_line();
    step(8'h21, "R2 restart after partial line");
    end_line();
  endtask

  task automatic t_orders();
    defaults(); cfg_yuv_ylead = 1'b1;
    step(8'h40, "R3 Y"); step(8'h21, "R3 U"); step(8'h40, "R3 Y"); step(8'h93, "R3 V");
    end_line();
    cfg_uv_swap = 1'b1;
    step(8'h40, "R4 Y"); step(8'h93, "R4 V"); step(8'h40, "R4 Y"); step(8'h21, "R4 U");
    end_line();
    cfg_yuv_ylead = 1'b0;
    step(8'h93, "R4 V lead"); step(8'h40, "R4 Y"); step(8'h21, "R4 U"); step(8'h40, "R4 Y");
    end_line();
  endtask

  task automatic t_fixed_chroma();
    defaults(); cfg_fix_uv = 1'b1; cfg_fix_u = 8'h7A; cfg_fix_v = 8'h5C;
    step(8'h7A, "R5 fixed U"); step(8'h40, "R5 Y kept");
    step(8'h5C, "R5 fixed V"); step(8'h40, "R5 Y kept");
    end_line();
  endtask

  task automatic t_rgb();
    defaults(); cfg_rgb_en = 1'b1; cfg_rgb_mode = 2'b01;
    in_r = 8'hF8; in_g = 8'h84; in_b = 8'h28;
    step(8'hFC, "R6 565 high"); step(8'h25, "R6 565 low");
    in_r = 8'h10; in_g = 8'hFC; in_b = 8'hF8;
    step(8'h17, "R6 565 high p2"); step(8'hFF, "R6 565 low p2");
    end_line();
    in_r = 8'hF8; in_g = 8'h84; in_b = 8'h28;
    cfg_rb_swap = 1'b1;
    step(8'h2C, "R8 565 swap high"); step(8'h3F, "R8 565 swap low");
    end_line();
    cfg_rb_swap = 1'b0; cfg_rgb_mode = 2'b11;
    step(8'h7E, "R7 555 high"); step(8'h05, "R7 555 low");
    end_line();
    cfg_rb_swap = 1'b1;
    step(8'h16, "R8 555 swap high"); step(8'h1F, "R8 555 swap low");
    end_line();
  endtask

  task automatic t_rgb_bypass();
    defaults(); in_r = 8'hF8; in_g = 8'h84; in_b = 8'h28;
    cfg_rgb_en = 1'b1; cfg_rgb_mode = 2'b10;
    step(8'h21, "R9 mode bit0 low U"); step(8'h40, "R9 mode bit0 low Y");
    end_line();
    cfg_rgb_en = 1'b0; cfg_rgb_mode = 2'b01;
    step(8'h21, "R9 rgb off U"); step(8'h40, "R9 rgb off Y");
    end_line();
  endtask

  task automatic t_range();
    defaults(); in_u = 8'h00; in_y = 8'hFF; in_v = 8'h80;
    cfg_range = 2'b00;
    step(8'h10, "R10 std low"); step(8'hF0, "R10 std high"); step(8'h80, "R10 std mid");
    end_line();
    cfg_range = 2'b01;
    step(8'h10, "R10 std alt low"); step(8'hF0, "R10 std alt high");
    end_line();
    cfg_range = 2'b10;
    step(8'h01, "R10 ext low"); step(8'hFE, "R10 ext high");
    end_line();
    cfg_range = 2'b11;
    step(8'h00, "R10 full low"); step(8'hFF, "R10 full high");
    end_line();
  endtask

  task automatic t_bus();
    defaults(); in_u = 8'h01; in_y = 8'h40; in_v = 8'h92;
    cfg_bit_rev = 1'b1;
    step(8'h80, "R11 rev U"); step(8'h02, "R11 rev Y"); step(8'h49, "R11 rev V");
    end_line();
    cfg_bit_rev = 1'b0; cfg_end_swap = 1'b1;
    step(8'h80, "R12 swap U"); step(8'h40, "R12 swap Y"); step(8'h13, "R12 swap V");
    end_line();
    cfg_bit_rev = 1'b1;
    step(8'h01, "R12 rev then swap U"); step(8'h02, "R12 rev then swap Y");
    step(8'hC8, "R12 rev then swap V");
    end_line();
    cfg_end_swap = 1'b0; cfg_range = 2'b00; in_u = 8'h00;
    step(8'h08, "R11 clamp before reverse");
    end_line();
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    #1;
    t_reset();
    t_uyvy_restart();
    t_orders();
    t_fixed_chroma();
    t_rgb();
    t_rgb_bypass();
    t_range();
    t_bus();
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #(CLK_P * 20000);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL R1 watchdog: actual=hung expected=finished");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule